// File: doc/BRIEF.md
# Transmit Mode Timeout Controller

This block chooses whether a half-duplex modem transmits or listens. One mode-select input asks for transmit when it is low and for receive when it is high. A watchdog ends any transmit request that is held too long and returns the modem to receive. After such a forced return, a new transmission may only start once the select line has gone back to receive for a minimum number of cycles and then drops again. Two test inputs change this rule: one shortens the watchdog window and one switches the watchdog off entirely.

The block runs from a single 11.0592 MHz system clock, and every time window is a cycle count. The mode input is asynchronous and passes through a two-flop synchronizer before any decision uses it. An active-low reset puts the block in power-down: both enables are low and all state is cleared. The outputs are plain level flags plus a one-cycle timeout pulse, so there is no stream interface and no back-pressure.

Top module: `tmo_ctrl`

## Requirements
- R1: While `rst_n` is low, `tx_en`, `rx_en` and `tmo_pulse` are all 0, whatever the other inputs are. When reset is released, the block starts in receive mode with no lock pending.
- R2: `mode_req` = 0 asks for transmit and 1 asks for receive. A level change on `mode_req` reaches `tx_en` and `rx_en` after exactly two rising clock edges.
- R3: With `fast_test` = 0 and `no_timeout` = 0, an unbroken transmit period lasts exactly `NORMAL_LIMIT` cycles (33,177,600 by default). After that, `tx_en` falls and `rx_en` rises even though `mode_req` stays 0.
- R4: With `fast_test` = 1, the forced switch to receive happens after `FAST_LIMIT` cycles (16,368 by default) instead.
- R5: `tmo_pulse` is high for exactly one cycle. That cycle is the first cycle of a forced receive period.
- R6: After a forced switch, receive mode holds while `mode_req` stays 0. A return of `mode_req` to 1 that lasts fewer than `RELEASE_CYCLES` synchronized cycles does not re-arm transmit.
- R7: Once the synchronized `mode_req` has been 1 for `RELEASE_CYCLES` consecutive cycles (23 by default), the lock clears. A later 0 on `mode_req` starts transmit again.
- R8: While `no_timeout` = 1, no timeout occurs and no pulse is raised. Any pending lock is cleared, so `tx_en` follows the synchronized `mode_req` with no time limit.
- R9: `tx_en` and `rx_en` are never high together. Out of reset, exactly one of them is high.
- R10: A transmit period that the requester ends itself, by driving `mode_req` to 1, resets the watchdog. The next transmit period again gets the full window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 11.0592 MHz system clock |
| rst_n | input | 1 | Active-low reset and power-down |
| mode_req | input | 1 | Asynchronous mode select: 0 asks for transmit, 1 for receive |
| fast_test | input | 1 | Selects the short watchdog window |
| no_timeout | input | 1 | Disables the watchdog and the re-arm lock |
| tx_en | output | 1 | Transmit enabled |
| rx_en | output | 1 | Receive enabled |
| tmo_pulse | output | 1 | One-cycle flag at a forced switch to receive |

## Verification
The assertions tracing `tx_en` back to `mode_req` assume a fixed two-edge synchronizer latency. For that to hold, `mode_req` must settle between clock edges, and the bench only changes it on falling edges. The assertions also assume that `fast_test` and `no_timeout` are quasi-static control levels, which the stimulus changes only between test phases. The bench runs with shortened watchdog windows, so forced switches, the 22- versus 23-cycle release boundary and the bypass mode are all reached in a few thousand cycles.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

  typedef enum logic [1:0] {
    LINK_OFF = 2'd0,
    LINK_RX  = 2'd1,
    LINK_TX  = 2'd2
  } link_mode_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tmo_sync.sv
module tmo_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[i] <= RESET_VAL;
        end else begin
          chain_q[i] <= (i == 0) ? d : chain_q[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/tmo_run_timer.sv
module tmo_run_timer #(
  parameter int unsigned NORMAL_LIMIT = 33177600,
  parameter int unsigned FAST_LIMIT   = 16368
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic fast_sel,
  input  logic bypass,
  output logic fire
);

  localparam int unsigned CW = $clog2(tmo_pkg::max_of(NORMAL_LIMIT, FAST_LIMIT) + 1);
  localparam logic [CW-1:0] NORMAL_LAST = CW'(NORMAL_LIMIT - 1);
  localparam logic [CW-1:0] FAST_LAST   = CW'(FAST_LIMIT - 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] last_cnt;

  assign last_cnt = fast_sel ? FAST_LAST : NORMAL_LAST;
  assign fire     = active && !bypass && (run_q >= last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (active && !bypass && !fire) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

endmodule

// File: rtl/tmo_release_qual.sv
module tmo_release_qual #(
  parameter int unsigned RELEASE_CYCLES = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_hi,
  output logic qualified
);

  localparam int unsigned RW = $clog2(RELEASE_CYCLES + 1);
  localparam logic [RW-1:0] SAT  = RW'(RELEASE_CYCLES);
  localparam logic [RW-1:0] LAST = RW'(RELEASE_CYCLES - 1);

  logic [RW-1:0] hold_q;

  assign qualified = level_hi && (hold_q >= LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (!level_hi) begin
      hold_q <= '0;
    end else if (hold_q != SAT) begin
      hold_q <= hold_q + 1'b1;
    end
  end

endmodule

// File: rtl/tmo_ctrl.sv
module tmo_ctrl #(
  parameter int unsigned NORMAL_LIMIT   = 33177600,
  parameter int unsigned FAST_LIMIT     = 16368,
  parameter int unsigned RELEASE_CYCLES = 23,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_req,
  input  logic fast_test,
  input  logic no_timeout,
  output logic tx_en,
  output logic rx_en,
  output logic tmo_pulse
);

  import tmo_pkg::*;

  logic       req_rx_s;
  logic       lock_q;
  logic       pulse_q;
  logic       tx_active;
  logic       fire;
  logic       rearm_ok;
  link_mode_e link_mode;

  tmo_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (mode_req),
    .q     (req_rx_s)
  );

  assign tx_active = !req_rx_s && !lock_q;

  tmo_run_timer #(.NORMAL_LIMIT(NORMAL_LIMIT), .FAST_LIMIT(FAST_LIMIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (tx_active),
    .fast_sel (fast_test),
    .bypass   (no_timeout),
    .fire     (fire)
  );

  tmo_release_qual #(.RELEASE_CYCLES(RELEASE_CYCLES)) u_rel (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_hi  (req_rx_s),
    .qualified (rearm_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (no_timeout)    lock_q <= 1'b0;
      else if (fire)     lock_q <= 1'b1;
      else if (rearm_ok) lock_q <= 1'b0;
    end
  end

  always_comb begin
    if (!rst_n)         link_mode = LINK_OFF;
    else if (tx_active) link_mode = LINK_TX;
    else                link_mode = LINK_RX;
  end

  assign tx_en     = (link_mode == LINK_TX);
  assign rx_en     = (link_mode == LINK_RX);
  assign tmo_pulse = pulse_q;

endmodule

// File: rtl/tmo_ctrl_chk.sv
module tmo_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_req,
  input logic no_timeout,
  input logic tx_en,
  input logic rx_en,
  input logic tmo_pulse
);

  AST_ENABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en && rx_en)); // R9

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |=> !tmo_pulse); // R5

  AST_PULSE_ENDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |-> (!tx_en && rx_en && $past(tx_en))); // R3

  AST_BYPASS_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(no_timeout) |-> !tmo_pulse); // R8

  AST_TX_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> !$past(mode_req, 2)); // R2

endmodule

bind tmo_ctrl tmo_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_req   (mode_req),
  .no_timeout (no_timeout),
  .tx_en      (tx_en),
  .rx_en      (rx_en),
  .tmo_pulse  (tmo_pulse)
);

// File: tb/tmo_ctrl_test.sv
`timescale 1ns/1ps
module tmo_ctrl_test;

  localparam int NL  = 300;
  localparam int FL  = 40;
  localparam int REL = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_req = 1'b0;
  logic fast_test = 1'b0;
  logic no_timeout = 1'b0;
  logic tx_en, rx_en, tmo_pulse;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  tmo_ctrl #(.NORMAL_LIMIT(NL), .FAST_LIMIT(FL), .RELEASE_CYCLES(REL)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_req   (mode_req),
    .fast_test  (fast_test),
    .no_timeout (no_timeout),
    .tx_en      (tx_en),
    .rx_en      (rx_en),
    .tmo_pulse  (tmo_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, stepped on every rising edge
  bit m_s1 = 1'b1, m_s2 = 1'b1, m_lock = 1'b0, m_pulse = 1'b0;
  int m_run = 0, m_rel = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1'b1; m_s2 = 1'b1; m_lock = 1'b0; m_pulse = 1'b0;
      m_run = 0; m_rel = 0;
    end else begin
      bit txm, fire, unl;
      int lim;
      txm  = !m_s2 && !m_lock;
      lim  = fast_test ? FL : NL;
      fire = txm && !no_timeout && (m_run >= lim - 1);
      if (txm && !no_timeout && !fire) m_run = m_run + 1;
      else m_run = 0;
      unl = m_s2 && (m_rel >= REL - 1);
      if (no_timeout) m_lock = 1'b0;
      else if (fire)  m_lock = 1'b1;
      else if (unl)   m_lock = 1'b0;
      if (m_s2) m_rel = (m_rel < REL) ? m_rel + 1 : REL;
      else m_rel = 0;
      m_pulse = fire;
      m_s2 = m_s1;
      m_s1 = mode_req;
    end
  end

  always @(negedge clk) begin
    bit etx, erx;
    etx = rst_n && !m_s2 && !m_lock;
    erx = rst_n && !etx;
    check(tx_en === etx, "R2 R3 model tx_en", int'(tx_en), int'(etx));
    check(rx_en === erx, "R9 model rx_en", int'(rx_en), int'(erx));
    check(tmo_pulse === (rst_n && m_pulse), "R5 model tmo_pulse", int'(tmo_pulse), int'(m_pulse));
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts tx_en-high cycles from the current falling edge, stops on the first low one
  task automatic measure_tx(output int len);
    len = 0;
    while (tx_en && len < 5000) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int len;
    int pulses;
    // R1: power-down with a transmit request present
    cyc(3);
    check(!tx_en && !rx_en && !tmo_pulse, "R1 reset outputs", int'({tx_en, rx_en, tmo_pulse}), 0);
    mode_req = 1'b1;
    cyc(1);
    rst_n = 1'b1;
    cyc(2);
    check(rx_en && !tx_en, "R1 receive after reset", int'(rx_en), 1);

    // R2: two-edge latency on a transmit request
    mode_req = 1'b0;
    cyc(1);
    check(!tx_en, "R2 one edge after request", int'(tx_en), 0);
    cyc(1);
    check(tx_en && !rx_en, "R2 two edges after request", int'(tx_en), 1);

    // R3, R5: normal-window forced switch
    measure_tx(len);
    check(len == NL, "R3 normal window length", len, NL);
    check(tmo_pulse && rx_en, "R5 pulse at first forced receive cycle", int'(tmo_pulse), 1);
    cyc(1);
    check(!tmo_pulse, "R5 pulse lasts one cycle", int'(tmo_pulse), 0);

    // R6: lock holds with request still low, and through a short release
    cyc(50);
    check(!tx_en && rx_en, "R6 lock with request held", int'(tx_en), 0);
    mode_req = 1'b1;
    cyc(REL - 1);
    mode_req = 1'b0;
    cyc(10);
    check(!tx_en, "R6 release of REL-1 cycles ignored", int'(tx_en), 0);

    // R7: release of exactly REL cycles re-arms
    mode_req = 1'b1;
    cyc(REL);
    mode_req = 1'b0;
    cyc(3);
    check(tx_en, "R7 re-arm after REL cycles", int'(tx_en), 1);

    // R10 with R4: voluntary end restarts the fast window
    fast_test = 1'b1;
    mode_req = 1'b1;
    cyc(4);
    mode_req = 1'b0;
    cyc(2 + 30);
    mode_req = 1'b1;
    cyc(3);
    check(!tx_en && !tmo_pulse, "R10 voluntary end without timeout", int'(tx_en), 0);
    mode_req = 1'b0;
    cyc(2);
    measure_tx(len);
    check(len == FL, "R4 R10 full fast window after voluntary end", len, FL);
    check(tmo_pulse, "R4 pulse after fast window", int'(tmo_pulse), 1);

    // R8: bypass clears lock and removes the limit
    no_timeout = 1'b1;
    cyc(2);
    check(tx_en, "R8 bypass clears lock", int'(tx_en), 1);
    pulses = 0;
    for (int i = 0; i < 500; i++) begin
      cyc(1);
      if (tmo_pulse || !tx_en) pulses++;
    end
    check(pulses == 0, "R8 unlimited transmit in bypass", pulses, 0);
    mode_req = 1'b1;
    cyc(2);
    check(rx_en && !tx_en, "R8 mode follows input in bypass", int'(rx_en), 1);
    no_timeout = 1'b0;
    fast_test = 1'b0;

    // R1: reset during transmit
    mode_req = 1'b0;
    cyc(5);
    check(tx_en, "R2 transmit before mid-run reset", int'(tx_en), 1);
    rst_n = 1'b0;
    #1;
    check(!tx_en && !rx_en, "R1 mid-run reset outputs", int'({tx_en, rx_en}), 0);
    cyc(2);
    mode_req = 1'b1;
    rst_n = 1'b1;
    cyc(3);
    check(rx_en, "R1 receive after mid-run reset", int'(rx_en), 1);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule